// File: doc/BRIEF.md
# TLB Replacement Victim Index Picker

This block chooses which TLB entry a random-replacement write should overwrite. It keeps a 32-bit linear congruential state. Each accepted request advances that state with a fixed multiplier and increment. The upper half of the new state is reduced modulo the number of non-wired entries, and the wired count is added to the remainder. Entries held below the wired boundary are therefore never chosen.

The reduction is a bit-serial restoring remainder unit. It handles a range of up to 64 entries and takes one cycle per dividend bit. A request starts a pick and latches the wired count, so later changes to the wired input do not affect that pick. The result is registered and held until the next pick finishes. A one-cycle valid pulse marks each new result.

Top module: `tvp_victim_pick`

## Requirements
- R1: After reset, `idx_o` is 0, `vld_o` is 0 and the internal state is 0. The first pick after reset therefore returns the wired count (state 1, upper half 0) when wired is below ENTRIES.
- R2: Each accepted request replaces the 32-bit state S with (S * 314159 + 1) mod 2^32.
- R3: The value reduced is bits [31:16] of the state after the update. The index equals (that value mod (ENTRIES - wired)) + wired, so it lies in [wired, ENTRIES-1].
- R4: The wired count is sampled in the cycle a request is accepted. Changes to `wired_i` while a pick is in progress have no effect on that pick.
- R5: When the sampled wired count is at least ENTRIES, the index is ENTRIES-1, no division by zero occurs, and the state still advances.
- R6: `vld_o` rises exactly 17 clock edges after the edge that accepts the request and stays high for exactly one cycle.
- R7: `idx_o` keeps its value in every cycle in which `vld_o` is low.
- R8: A request that arrives while a pick is in progress is ignored. It neither advances the state nor produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe for a new victim index |
| wired_i | input | $clog2(ENTRIES)+1 | Number of wired (protected) low entries |
| idx_o | output | $clog2(ENTRIES) | Chosen victim index |
| vld_o | output | 1 | One-cycle pulse when a new index is ready |

## Verification
A request accepted at clock edge E produces its index, with `vld_o` high, after edge E+17. A new request is accepted from edge E+18 onwards.

The driver computes the expected index from a software model of the generator and queues it. It also queues the cycle number at which the result is due. The monitor samples on falling edges, pops both values whenever `vld_o` is high, and compares the index and the arrival cycle.

In every cycle without a valid pulse, the monitor checks that the held index is unchanged. The driver disturbs `wired_i` and injects extra requests during each pick. A wrongly accepted request shows up either as an unexpected result or as a drift in every later index.

// File: rtl/tvp_pkg.sv
package tvp_pkg;
  localparam int unsigned  ST_W    = 32;
  localparam int unsigned  SEL_LSB = 16;
  localparam int unsigned  SEL_W   = ST_W - SEL_LSB;
  localparam logic [ST_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [ST_W-1:0] LCG_INC = 32'd1;
endpackage

// File: rtl/tvp_lcg.sv
module tvp_lcg
  import tvp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [ST_W-1:0] st_o,
  output logic [ST_W-1:0] st_nxt_o
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;
  logic [ST_W-1:0] st_step;

  always_comb begin
    st_step = st_q * LCG_MUL + LCG_INC;
    st_d    = adv_i ? st_step : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else if (adv_i) st_q <= st_d;
  end

  assign st_o     = st_q;
  assign st_nxt_o = st_step;

  // R2: state only moves on an accepted request
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(st_o));
endmodule

// File: rtl/tvp_modu.sv
module tvp_modu #(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [RW-1:0] dvs_i,
  output logic          done_o,
  output logic [RW-1:0] rem_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [RW-1:0] rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [RW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [RW-1:0] trial;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    trial  = {rem_q[RW-2:0], quo_q[DW-1]};
    if (start_i) begin
      rem_d = '0;
      quo_d = dvd_i;
      dvs_d = dvs_i;
      cnt_d = CW'(DW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = (trial >= dvs_q) ? (trial - dvs_q) : trial;
      quo_d = {quo_q[DW-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

  // R3: finished remainder is below the latched divisor
  a_r3_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));
  // R5: divisor is never zero during a reduction
  a_r5_no_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (dvs_q != '0));
endmodule

// File: rtl/tvp_victim_pick.sv
module tvp_victim_pick
  import tvp_pkg::*;
#(
  parameter int unsigned ENTRIES = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_i,
  input  logic [$clog2(ENTRIES):0]      wired_i,
  output logic [$clog2(ENTRIES)-1:0]    idx_o,
  output logic                          vld_o
);
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned WIRED_W = IDX_W + 1;
  localparam int unsigned RW      = IDX_W + 2;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

  logic              busy_q, busy_d;
  logic              sat_q, sat_d;
  logic [IDX_W-1:0]  base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              vld_q, vld_d;
  logic              accept;
  logic              sat_now;
  logic [RW-1:0]     span;
  logic [RW-1:0]     dvs;
  logic [ST_W-1:0]   st_cur, st_nxt;
  logic              m_done;
  logic [RW-1:0]     m_rem;

  tvp_lcg u_lcg (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (accept),
    .st_o     (st_cur),
    .st_nxt_o (st_nxt)
  );

  tvp_modu #(.DW(SEL_W), .RW(RW)) u_modu (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .dvd_i   (st_nxt[ST_W-1:SEL_LSB]),
    .dvs_i   (dvs),
    .done_o  (m_done),
    .rem_o   (m_rem)
  );

  always_comb begin
    accept  = req_i && !busy_q;
    sat_now = ({1'b0, wired_i} >= (WIRED_W+1)'(ENTRIES));
    span    = RW'(ENTRIES) - RW'(wired_i);
    dvs     = sat_now ? RW'(1) : span;

    busy_d = busy_q;
    sat_d  = sat_q;
    base_d = base_q;
    idx_d  = idx_q;
    vld_d  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      sat_d  = sat_now;
      base_d = wired_i[IDX_W-1:0];
    end else if (m_done) begin
      busy_d = 1'b0;
      vld_d  = 1'b1;
      idx_d  = sat_q ? TOP_IDX : (m_rem[IDX_W-1:0] + base_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sat_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sat_q  <= sat_d;
      base_q <= base_d;
      idx_q  <= idx_d;
      vld_q  <= vld_d;
    end
  end

  assign idx_o = idx_q;
  assign vld_o = vld_q;

  // R3: index never below the latched wired boundary, never past the table
  a_r3_idx_window: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !sat_q) |-> ((idx_o >= base_q) && (32'(idx_o) < ENTRIES)));
  // R6: valid is a single-cycle pulse
  a_r6_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
  // R7: index holds between results
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> $stable(idx_o));
  // R8: a request during a pick leaves the generator state untouched
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_i) |=> $stable(st_cur));
endmodule

// File: tb/tb_tvp_victim_pick.sv
`timescale 1ns/1ps
module tb_tvp_victim_pick;
  localparam int N  = 48;
  localparam int IW = 6;
  localparam int WW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [WW-1:0] wired = '0;
  logic [IW-1:0] idx;
  logic          vld;

  tvp_victim_pick #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx), .vld_o(vld)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    exp_q[$];
  int    due_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  logic [31:0]   m_st = '0;
  logic [IW-1:0] last_idx = '0;
  logic          prev_vld = 1'b0;
  bit            finished = 1'b0;
  int            pick[7] = '{0, 1, 5, 23, 47, 48, 70};

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // driver: model the generator, queue the expectation, then disturb inputs
  task automatic do_req(input int w, input bit poke, input bit first);
    int e;
    logic [31:0] u;
    @(negedge clk);
    req   = 1'b1;
    wired = WW'(w);
    m_st  = m_st * 32'd314159 + 32'd1;   // R2
    u     = m_st >> 16;
    e     = (w >= N) ? N - 1 : int'(u % 32'(N - w)) + w;
    exp_q.push_back(e);
    due_q.push_back(cyc + 18);
    if (first)       tag_q.push_back("R1 first pick after reset");
    else if (w >= N) tag_q.push_back("R5 saturated wired");
    else             tag_q.push_back("R3 R2 index sequence");
    @(negedge clk);
    req   = 1'b0;
    wired = WW'((w * 13 + 9) % 128);     // R4 disturbance during the pick
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      req = (poke && k == 4) ? 1'b1 : 1'b0;  // R8 request while busy
      if (k == 8) wired = WW'((w * 7 + 3) % 128);
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vld) begin
        chk(!prev_vld, "R6 single-cycle valid", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", int'(idx), -1);
        end else begin
          int e, d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(idx) == e, t, int'(idx), e);
          chk(cyc == d, "R6 latency", cyc, d);
        end
        last_idx = idx;
      end else begin
        chk(idx == last_idx, "R7 index hold", int'(idx), int'(last_idx));
      end
      prev_vld = vld;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(idx == '0, "R1 reset index", int'(idx), 0);
    chk(vld == 1'b0, "R1 reset valid", int'(vld), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 1050; i++) begin
      do_req(pick[i % 7], (i % 50) == 3, i == 0);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule